// File: doc/BRIEF.md
# Event Timer Global Register Block

This block holds the shared registers of a multi-channel event timer: a fixed identity and capability word, a two-bit configuration register, a per-channel interrupt status register and a 64-bit main counter. It sits on a simple register bus. The bus carries a byte address, 64-bit write data, a size select that picks a 32-bit or 64-bit access, and separate read and write strobes. The block decodes every access in its 0x400-byte window. It serves the global registers itself. Offsets from 0x100 upward go to per-channel register groups, 0x20 bytes apart. The bus signals reach the channels directly, and this block adds a one-hot channel select, a register code and a write strobe for them. It reads back whatever the selected channel presents.

The configuration outputs are the global enable and the legacy-route bit. These and the running counter value are the common time base for the comparator channels. Each channel reports level-triggered events through a per-channel status set input. Software clears those events by writing ones to the status register. On the clock edge that ends a clear, the block raises a clear pulse to the channel, so that the channel can drop its request.

Top module: `evt_glob_regs`

## Requirements
- R1: After reset the configuration, the status bits, the main counter and the read data are all zero, and the channel select is zero.
- R2: The capability register at offset 0x000 reads as: revision 0x01 in bits 7:0, channel count minus one in bits 12:8, a 1 in bit 13 (64-bit counter), a 1 in bit 15 (legacy route capable), the vendor ID in bits 31:16 and the tick period in femtoseconds in bits 63:32. With the default parameters this is 0x00989680_A5C3A201. Writes to it change nothing.
- R3: In the configuration register at offset 0x010, bit 0 is the enable and bit 1 is the legacy-route bit. Only these two bits are writable, and every other bit reads 0. The enable drives `glb_en` and the legacy-route bit drives `legacy_rt`.
- R4: Address bit 2 selects the upper 32-bit half. A 32-bit access reads that half into `bus_rdata[31:0]` with zero above it, and it writes only that half. A 64-bit access with bit 2 clear reads and writes all 64 bits.
- R5: While the enable is 0, the main counter at offset 0x0F0 holds its value, and a write loads the written half or halves.
- R6: While the enable is 1, the counter advances by one on each edge where `tick_en` is 1. A counter write made while enabled loads its value in place of that edge's increment. Setting the enable does not count on the edge that writes it.
- R7: A 1 on `status_set[i]` sets status bit i of the register at offset 0x020 on the next edge.
- R8: Writing 1 to a status bit that is set clears it, and `irq_clr[i]` is high during that write. Writing 0, or writing 1 to a bit that is clear, has no effect. If a set request and a clear arrive on the same edge, the set wins and no clear pulse is given.
- R9: Offsets 0x100 + i*0x20 with i below the channel count select channel i: `tmr_sel` is one-hot at bit i. `tmr_reg` is offset bits 4:3, where 0 is configuration, 1 is comparator and 2 is route. A read returns the channel's `tmr_rdata` word, and a write raises `tmr_wr`.
- R10: These accesses read 0 and change nothing: a channel index at or beyond the count, register code 3, and undefined global offsets. For such accesses `tmr_sel` is 0 and `tmr_wr` stays low.
- R11: Read data is registered. It appears on the edge that samples `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter tick qualifier |
| bus_addr | input | ADDR_W-2 | Byte address bits ADDR_W-1:2 |
| bus_size64 | input | 1 | 1 selects a 64-bit access, 0 a 32-bit access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 64 | Write data (32-bit data in bits 31:0) |
| bus_rdata | output | 64 | Registered read data |
| glb_en | output | 1 | Global enable |
| legacy_rt | output | 1 | Legacy-route bit |
| main_count | output | 64 | Main counter value |
| status_set | input | NT | Per-channel level event set requests |
| int_status | output | NT | Interrupt status bits |
| irq_clr | output | NT | Per-channel clear pulse |
| tmr_sel | output | NT | One-hot channel select |
| tmr_reg | output | 2 | Channel register code |
| tmr_wr | output | 1 | Channel write strobe |
| tmr_rdata | input | NT*64 | Per-channel read words, channel i in bits 64i+63:64i |

## Verification
The counter is driven with `tick_en` held high, held low, and toggled every other cycle. These patterns separate gating by the enable from gating by the tick input, and exact counts at known edges show whether a write takes priority over an increment. The status register is written with zeros, with ones on clear bits, with ones on set bits, and with a one on the same edge as a set request. Together these separate correct W1C from plain writes and from set-over-clear priority. Addresses cover both halves in 32-bit accesses, each channel register code, code 3, an index one past the count, and an undefined global offset. This shows that decode, half selection and ignore paths are distinct.

// File: rtl/evt_pkg.sv
package evt_pkg;

  typedef enum logic [2:0] {
    GK_NONE,
    GK_CAP,
    GK_CFG,
    GK_STS,
    GK_CNT
  } glb_kind_e;

  localparam int unsigned WORD_W = 64;
  localparam int unsigned HALF_W = 32;

endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec #(
  parameter int unsigned NT     = 3,
  parameter int unsigned ADDR_W = 10
) (
  input  logic [ADDR_W-1:3]     addr,
  output evt_pkg::glb_kind_e    kind,
  output logic                  hit,
  output logic [NT-1:0]         sel,
  output logic [1:0]            rcode
);
  import evt_pkg::*;

  localparam int unsigned IW = ADDR_W - 5;
  localparam logic [IW-1:0] NT_W   = IW'(NT);
  localparam logic [IW-1:0] BASE_W = IW'(8);

  logic          is_glb;
  logic [IW-1:0] idx;

  always_comb begin
    is_glb = (addr[ADDR_W-1:8] == '0);
    idx    = addr[ADDR_W-1:5] - BASE_W;
    rcode  = addr[4:3];
    kind   = GK_NONE;
    if (is_glb) begin
      case (addr[7:3])
        5'h00:   kind = GK_CAP;
        5'h02:   kind = GK_CFG;
        5'h04:   kind = GK_STS;
        5'h1E:   kind = GK_CNT;
        default: kind = GK_NONE;
      endcase
    end
    hit = !is_glb && (rcode != 2'd3) && (idx < NT_W);
  end

  for (genvar i = 0; i < NT; i++) begin : g_sel
    assign sel[i] = hit && (idx == IW'(i));
  end

endmodule

// File: rtl/evt_main_ctr.sv
module evt_main_ctr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        tick_en,
  input  logic        wr,
  input  logic [63:0] wmask,
  input  logic [63:0] wval,
  output logic [63:0] cnt
);
  logic [63:0] cnt_q, cnt_d;
  logic        cnt_ld;

  always_comb begin
    cnt_ld = wr || (run && tick_en);
    if (wr) cnt_d = (wval & wmask) | (cnt_q & ~wmask);
    else    cnt_d = cnt_q + 64'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/evt_int_sts.sv
module evt_int_sts #(
  parameter int unsigned NT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] set,
  input  logic          wr,
  input  logic [NT-1:0] wbits,
  output logic [NT-1:0] sts,
  output logic [NT-1:0] clr_pulse
);
  logic [NT-1:0] sts_q, sts_d, clr_req;
  logic          sts_ld;

  always_comb begin
    clr_req   = wr ? wbits : '0;
    clr_pulse = clr_req & sts_q & ~set;
    sts_d     = (sts_q & ~clr_req) | set;
    sts_ld    = wr || (set != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_ld) sts_q <= sts_d;
  end

  assign sts = sts_q;

endmodule

// File: rtl/evt_glob_regs.sv
module evt_glob_regs #(
  parameter int unsigned NT        = 3,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned VENDOR_ID = 16'hA5C3,
  parameter int unsigned PERIOD_FS = 10_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [ADDR_W-1:2] bus_addr,
  input  logic             bus_size64,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [63:0]      bus_wdata,
  output logic [63:0]      bus_rdata,
  output logic             glb_en,
  output logic             legacy_rt,
  output logic [63:0]      main_count,
  input  logic [NT-1:0]    status_set,
  output logic [NT-1:0]    int_status,
  output logic [NT-1:0]    irq_clr,
  output logic [NT-1:0]    tmr_sel,
  output logic [1:0]       tmr_reg,
  output logic             tmr_wr,
  input  logic [NT*64-1:0] tmr_rdata
);
  import evt_pkg::*;

  localparam logic [63:0] CAP_VAL = {32'(PERIOD_FS), 16'(VENDOR_ID),
                                     1'b1, 1'b0, 1'b1, 5'(NT - 1), 8'h01};

  glb_kind_e   kind;
  logic        hit;
  logic        hi, wide;
  logic [63:0] wmask, wlane, raw, rd_d;
  logic [63:0] rd_q;
  logic        en_q, en_d, leg_q, leg_d, cfg_wr;

  evt_addr_dec #(.NT(NT), .ADDR_W(ADDR_W)) u_dec (
    .addr  (bus_addr[ADDR_W-1:3]),
    .kind  (kind),
    .hit   (hit),
    .sel   (tmr_sel),
    .rcode (tmr_reg)
  );

  always_comb begin
    hi    = bus_addr[2];
    wide  = bus_size64 && !hi;
    wmask = wide ? '1 : (hi ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF});
    wlane = hi ? {bus_wdata[31:0], 32'h0} : bus_wdata;
  end

  assign tmr_wr = bus_wr && hit;

  evt_main_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_q),
    .tick_en (tick_en),
    .wr      (bus_wr && (kind == GK_CNT)),
    .wmask   (wmask),
    .wval    (wlane),
    .cnt     (main_count)
  );

  evt_int_sts #(.NT(NT)) u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       (status_set),
    .wr        (bus_wr && (kind == GK_STS)),
    .wbits     (wlane[NT-1:0] & wmask[NT-1:0]),
    .sts       (int_status),
    .clr_pulse (irq_clr)
  );

  // configuration next state
  always_comb begin
    cfg_wr = bus_wr && (kind == GK_CFG);
    en_d   = (cfg_wr && wmask[0]) ? wlane[0] : en_q;
    leg_d  = (cfg_wr && wmask[1]) ? wlane[1] : leg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      leg_q <= 1'b0;
    end else if (cfg_wr) begin
      en_q  <= en_d;
      leg_q <= leg_d;
    end
  end

  assign glb_en    = en_q;
  assign legacy_rt = leg_q;

  // read path
  always_comb begin
    raw = '0;
    case (kind)
      GK_CAP:  raw = CAP_VAL;
      GK_CFG:  raw = {62'h0, leg_q, en_q};
      GK_STS:  raw = 64'(int_status);
      GK_CNT:  raw = main_count;
      default: begin
        for (int i = 0; i < NT; i++) begin
          if (tmr_sel[i]) raw = tmr_rdata[i*64 +: 64];
        end
      end
    endcase
    rd_d = wide ? raw : {32'h0, (hi ? raw[63:32] : raw[31:0])};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (bus_rd) rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;

endmodule

// File: rtl/evt_glob_regs_chk.sv
module evt_glob_regs_chk #(
  parameter int unsigned NT        = 3,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned VENDOR_ID = 16'hA5C3,
  parameter int unsigned PERIOD_FS = 10_000_000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [ADDR_W-1:2] bus_addr,
  input logic             bus_size64,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [63:0]      bus_wdata,
  input logic [63:0]      bus_rdata,
  input logic             glb_en,
  input logic             legacy_rt,
  input logic [63:0]      main_count,
  input logic [NT-1:0]    status_set,
  input logic [NT-1:0]    int_status,
  input logic [NT-1:0]    irq_clr,
  input logic [NT-1:0]    tmr_sel,
  input logic [1:0]       tmr_reg,
  input logic             tmr_wr,
  input logic [NT*64-1:0] tmr_rdata
);
  localparam logic [63:0] CAP_EXP = {32'(PERIOD_FS), 16'(VENDOR_ID), 8'hA0, 8'h01}
                                    | (64'(NT - 1) << 8);

  logic unused_ok;
  assign unused_ok = ^{bus_wdata, legacy_rt, tmr_reg, tmr_rdata};

  a_r2_cap_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_size64 && (bus_addr == '0) |=> bus_rdata == CAP_EXP);

  a_r5_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en && !bus_wr |=> $stable(main_count));

  a_r6_run_step: assert property (@(posedge clk) disable iff (!rst_n)
    glb_en && tick_en && !bus_wr |=> main_count == $past(main_count) + 64'd1);

  a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (status_set != '0) |=> (int_status & $past(status_set)) == $past(status_set));

  a_r8_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr != '0) |=> (int_status & $past(irq_clr)) == '0);

  a_r8_sts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr && (status_set == '0) |=> $stable(int_status));

  a_r9_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_sel));

  a_r10_wr_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |-> $countones(tmr_sel) == 1);

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind evt_glob_regs evt_glob_regs_chk #(
  .NT(NT), .ADDR_W(ADDR_W), .VENDOR_ID(VENDOR_ID), .PERIOD_FS(PERIOD_FS)
) u_chk (.*);

// File: tb/evt_glob_regs_test.sv
module evt_glob_regs_test;
  localparam int NT = 3;
  localparam int AW = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick_en = 1'b0;
  logic [AW-1:2]    bus_addr = '0;
  logic             bus_size64 = 1'b0;
  logic             bus_rd = 1'b0;
  logic             bus_wr = 1'b0;
  logic [63:0]      bus_wdata = '0;
  logic [63:0]      bus_rdata;
  logic             glb_en, legacy_rt;
  logic [63:0]      main_count;
  logic [NT-1:0]    status_set = '0;
  logic [NT-1:0]    int_status, irq_clr, tmr_sel;
  logic [1:0]       tmr_reg;
  logic             tmr_wr;
  logic [NT*64-1:0] tmr_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [NT-1:0] cap_clr, cap_sel;
  logic          cap_twr;
  logic [63:0]   rv, v0;

  always #2 clk = ~clk;

  evt_glob_regs uut (.*);

  // channel model: a recognisable word per channel and register code
  always_comb begin
    for (int i = 0; i < NT; i++)
      tmr_rdata[i*64 +: 64] = {32'hC000_0000 + 32'(i*16) + 32'(tmr_reg),
                               32'h7000_0000 + 32'(i*16) + 32'(tmr_reg)};
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic s64, input logic [63:0] d);
    @(negedge clk);
    bus_addr = a[AW-1:2]; bus_size64 = s64; bus_wdata = d; bus_wr = 1'b1;
    #1;
    cap_clr = irq_clr; cap_sel = tmr_sel; cap_twr = tmr_wr;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a, input logic s64, output logic [63:0] d);
    @(negedge clk);
    bus_addr = a[AW-1:2]; bus_size64 = s64; bus_rd = 1'b1;
    #1;
    cap_sel = tmr_sel;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    chk("R1 cfg outputs", {62'h0, legacy_rt, glb_en}, 64'h0);
    chk("R1 count", main_count, 64'h0);
    chk("R1 status", 64'(int_status), 64'h0);
    chk("R1 rdata", bus_rdata, 64'h0);
    chk("R1 sel", 64'(tmr_sel), 64'h0);
  endtask

  task automatic t_cap;
    do_rd(12'h000, 1'b1, rv); chk("R2 cap 64", rv, 64'h0098_9680_A5C3_A201);
    do_rd(12'h000, 1'b0, rv); chk("R4 cap lo half", rv, 64'h0000_0000_A5C3_A201);
    do_rd(12'h004, 1'b0, rv); chk("R4 cap hi half", rv, 64'h0000_0000_0098_9680);
    do_wr(12'h000, 1'b1, '1);
    do_rd(12'h000, 1'b1, rv); chk("R2 cap read-only", rv, 64'h0098_9680_A5C3_A201);
    chk("R11 rdata holds", bus_rdata, 64'h0098_9680_A5C3_A201);
  endtask

  task automatic t_cfg;
    do_wr(12'h010, 1'b1, '1);
    do_rd(12'h010, 1'b1, rv); chk("R3 cfg mask", rv, 64'h3);
    chk("R3 outputs", {62'h0, legacy_rt, glb_en}, 64'h3);
    do_wr(12'h014, 1'b0, 64'hFFFF_FFFF);
    do_rd(12'h010, 1'b1, rv); chk("R3 upper half no effect", rv, 64'h3);
    do_wr(12'h010, 1'b1, 64'h0);
    chk("R3 cleared", {62'h0, legacy_rt, glb_en}, 64'h0);
  endtask

  task automatic t_halt;
    do_wr(12'h0F0, 1'b1, 64'h0);
    do_wr(12'h0F0, 1'b0, 64'h0000_0010);
    do_wr(12'h0F4, 1'b0, 64'h0000_0001);
    chk("R5 halted write", main_count, 64'h1_0000_0010);
    tick_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 halted hold", main_count, 64'h1_0000_0010);
    do_rd(12'h0F4, 1'b0, rv); chk("R4 count hi half", rv, 64'h1);
    do_rd(12'h0F0, 1'b1, rv); chk("R5 count read", rv, 64'h1_0000_0010);
  endtask

  task automatic t_run;
    do_wr(12'h010, 1'b1, 64'h1);
    chk("R6 enable edge no count", main_count, 64'h1_0000_0010);
    repeat (5) @(negedge clk);
    chk("R6 five ticks", main_count, 64'h1_0000_0015);
    do_wr(12'h0F0, 1'b1, 64'h1234);
    chk("R6 write wins", main_count, 64'h1234);
    @(negedge clk);
    chk("R6 resumes from write", main_count, 64'h1235);
  endtask

  task automatic t_gate;
    tick_en = 1'b0;
    v0 = main_count;
    repeat (4) @(negedge clk);
    chk("R6 tick_en low holds", main_count, v0);
    for (int k = 0; k < 10; k++) begin
      tick_en = (k % 2 == 0);
      @(negedge clk);
    end
    tick_en = 1'b0;
    chk("R6 toggled ticks", main_count, v0 + 64'd5);
  endtask

  task automatic t_freeze;
    tick_en = 1'b1;
    do_wr(12'h010, 1'b1, 64'h0);
    v0 = main_count;
    repeat (3) @(negedge clk);
    chk("R5 frozen", main_count, v0);
    do_wr(12'h010, 1'b1, 64'h1);
    repeat (3) @(negedge clk);
    chk("R6 resumes from frozen", main_count, v0 + 64'd3);
    tick_en = 1'b0;
    do_wr(12'h010, 1'b1, 64'h0);
  endtask

  task automatic t_status;
    @(negedge clk); status_set = 3'b010;
    @(negedge clk); status_set = '0;
    chk("R7 set", 64'(int_status), 64'h2);
    do_wr(12'h020, 1'b1, 64'h0);
    chk("R8 write zero", 64'(int_status), 64'h2);
    do_wr(12'h020, 1'b1, 64'h4);
    chk("R8 clear bit ignored", 64'(int_status), 64'h2);
    chk("R8 no pulse", 64'(cap_clr), 64'h0);
    do_wr(12'h020, 1'b1, 64'h2);
    chk("R8 pulse", 64'(cap_clr), 64'h2);
    chk("R8 cleared", 64'(int_status), 64'h0);
    @(negedge clk); status_set = 3'b001;
    @(negedge clk); status_set = '0;
    @(negedge clk);
    bus_addr = 8'h08; bus_size64 = 1'b1; bus_wdata = 64'h1; bus_wr = 1'b1; status_set = 3'b001;
    #1; cap_clr = irq_clr;
    @(negedge clk); bus_wr = 1'b0; status_set = '0;
    chk("R8 set wins", 64'(int_status), 64'h1);
    chk("R8 set wins no pulse", 64'(cap_clr), 64'h0);
    do_rd(12'h020, 1'b1, rv); chk("R7 status read", rv, 64'h1);
    do_wr(12'h020, 1'b1, 64'h1);
  endtask

  task automatic t_decode;
    do_rd(12'h120, 1'b1, rv);
    chk("R9 t1 cfg", rv, 64'hC000_0010_7000_0010);
    chk("R9 t1 sel", 64'(cap_sel), 64'h2);
    do_rd(12'h12C, 1'b0, rv);
    chk("R9 t1 cmp hi", rv, 64'hC000_0011);
    do_rd(12'h150, 1'b0, rv);
    chk("R9 t2 route lo", rv, 64'h7000_0022);
    do_wr(12'h140, 1'b1, 64'h5);
    chk("R9 t2 write strobe", {cap_twr, 60'h0, cap_sel}, {1'b1, 60'h0, 3'b100});
    do_rd(12'h160, 1'b1, rv);
    chk("R10 out of range read", rv, 64'h0);
    chk("R10 out of range sel", 64'(cap_sel), 64'h0);
    do_rd(12'h118, 1'b1, rv);
    chk("R10 code3 read", rv, 64'h0);
    do_wr(12'h160, 1'b1, '1);
    chk("R10 no write strobe", {63'h0, cap_twr}, 64'h0);
    do_rd(12'h030, 1'b1, rv);
    chk("R10 undefined global", rv, 64'h0);
    v0 = main_count;
    do_wr(12'h030, 1'b1, '1);
    chk("R10 undefined write cfg", {62'h0, legacy_rt, glb_en}, 64'h0);
    chk("R10 undefined write count", main_count, v0);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cap();
    t_cfg();
    t_halt();
    t_run();
    t_gate();
    t_freeze();
    t_status();
    t_decode();
    done = 1;
    finish_run();
  end

endmodule